// File: doc/BRIEF.md
# Object Method Dispatch Router

This block is a single-hop packet router whose destination is computed while the packet passes through it. A caller port injects a request packet. Its header word carries a method identifier and an object reference, and up to three parameter words follow. The object reference is made of a class identifier and an instance number. The router joins the method with the class to form a functional-unit key. It compares that key against a table of configured units and forwards the whole packet to the matching unit port. The binding of a virtual call to its implementation therefore happens during routing.

On the way out, the router writes the caller's port index into the header. A unit that answers sends back a reply packet whose header names that caller, so no lookup table is needed on the return path. The request and reply directions use separate arbiters. Replies can always drain, so a call in progress never waits on new requests. A request whose key matches no unit is discarded, and the router answers the caller with a one-word error reply.

Header word layout, shared by requests and replies:

| Bits | Field |
| --- | --- |
| [31:28] | method identifier |
| [27:24] | class identifier |
| [23:16] | instance number |
| [15:14] | count of words that follow (0 to 3) |
| [13] | error status |
| [7:0] | caller port index |

Top module: `omd_router`

## Requirements
- R1: After rst_ni is released with all inputs idle, every fu_valid_o and cl_valid_o bit is low.
- R2: The 8-bit key {method [31:28], class [27:24]} of a request header selects the functional-unit port j for which FU_MAP[j*8+:8] equals the key. The lowest j wins if several match. The header arrives there with bits [31:8] unchanged, so the instance [23:16] and the length [15:14] are kept, and bits [7:0] are replaced by the caller's port index. Parameter words are forwarded unchanged.
- R3: All 1+len words of a request reach one unit port, in order and back to back on that port. No word of another caller is interleaved, and every word leaving a unit port was taken from a caller port in the same cycle.
- R4: When several callers target the same unit, their packets are granted in round-robin order of caller index, one whole packet per grant.
- R5: While a unit port shows valid with ready low, valid stays high and the data stays stable, and no word is lost.
- R6: A reply packet from unit j is routed to the caller port given by the header bits [7:0]. All 1+len words are forwarded unchanged, except that bit 13 of the reply header is cleared.
- R7: A request with no matching key produces no word on any unit port. Its parameter words are consumed and discarded. The caller port then receives exactly one word: header bits [31:16] kept, [15:14] = 0, bit 13 = 1, bits [12:8] = 0, [7:0] = caller index.
- R8: At a caller port, a unit reply wins over a pending error reply. Once an error reply is presented, it stays until it is taken.
- R9: When several units reply to the same caller, their packets are granted in round-robin order of unit index, one whole packet per grant.
- R10: Requests from different callers to different units pass in the same cycles without waiting on each other.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | N_CALLER | Request word valid, per caller |
| req_data_i | input | N_CALLER x 32 | Request word, per caller |
| req_ready_o | output | N_CALLER | Request word accepted, per caller |
| fu_valid_o | output | N_FU | Dispatched word valid, per unit |
| fu_data_o | output | N_FU x 32 | Dispatched word, per unit |
| fu_ready_i | input | N_FU | Unit accepts word |
| rsp_valid_i | input | N_FU | Reply word valid, per unit |
| rsp_data_i | input | N_FU x 32 | Reply word, per unit |
| rsp_ready_o | output | N_FU | Reply word accepted, per unit |
| cl_valid_o | output | N_CALLER | Return word valid, per caller |
| cl_data_o | output | N_CALLER x 32 | Return word, per caller |
| cl_ready_i | input | N_CALLER | Caller accepts return word |

## Verification
Single requests with different keys and lengths show that the key, not the port of entry, picks the unit, and that the port index is written into the header. Simultaneous requests to one unit, and simultaneous replies to one caller, show round-robin order and unbroken packets. Simultaneous requests to different units show that independent paths do not wait on each other. A stalled unit port, an unmatched key followed by a valid request, and a unit reply that races an error reply to the same caller tell apart a correct hold, an exact drain count and the reply priority from a design that drops words, leaks parameter words or lets the error reply win.

// File: rtl/omd_pkg.sv
`timescale 1ns/1ps
package omd_pkg;
  localparam int WORD_W  = 32;
  localparam int KEY_W   = 8;
  localparam int LEN_W   = 2;
  localparam int PORT_W  = 8;
  localparam int ERR_BIT = 13;

  typedef logic [WORD_W-1:0] word_t;

  function automatic logic [KEY_W-1:0] key_of(word_t w);
    return w[31:24];
  endfunction

  function automatic logic [LEN_W-1:0] len_of(word_t w);
    return w[15:14];
  endfunction

  function automatic word_t stamp_src(word_t w, logic [PORT_W-1:0] p);
    return {w[31:8], p};
  endfunction

  function automatic word_t err_reply(word_t w, logic [PORT_W-1:0] p);
    return {w[31:16], 2'b00, 1'b1, 5'b00000, p};
  endfunction

  function automatic word_t clr_err(word_t w);
    word_t r;
    r = w;
    r[ERR_BIT] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/omd_pkt_seq.sv
`timescale 1ns/1ps
// Tracks header/body position of one input stream and holds its route.
module omd_pkt_seq #(
  parameter int TGT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hs_i,
  input  logic [1:0]       len_i,
  input  logic [TGT_W-1:0] tgt_i,
  output logic             hdr_o,
  output logic             last_o,
  output logic [TGT_W-1:0] tgt_o
);
  logic             body_q;
  logic [1:0]       cnt_q;
  logic [TGT_W-1:0] tgt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      body_q <= 1'b0;
      cnt_q  <= '0;
      tgt_q  <= '0;
    end else if (hs_i) begin
      if (!body_q) begin
        if (len_i != 2'd0) begin
          body_q <= 1'b1;
          cnt_q  <= len_i;
          tgt_q  <= tgt_i;
        end
      end else begin
        cnt_q <= cnt_q - 2'd1;
        if (cnt_q == 2'd1) body_q <= 1'b0;
      end
    end
  end

  assign hdr_o  = !body_q;
  assign last_o = body_q ? (cnt_q == 2'd1) : (len_i == 2'd0);
  assign tgt_o  = body_q ? tgt_q : tgt_i;
endmodule

// File: rtl/omd_rr_arb.sv
`timescale 1ns/1ps
// Round-robin arbiter; a grant, once shown, is held until the last word moves.
module omd_rr_arb #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] last_i,
  input  logic         xfer_i,
  output logic [N-1:0] gnt_o
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic          lock_q;
  logic [IW-1:0] lock_idx_q, ptr_q, pick, cur;
  logic          found;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (!found && req_i[(int'(ptr_q) + k) % N]) begin
        found = 1'b1;
        pick  = IW'((int'(ptr_q) + k) % N);
      end
    end
  end

  assign cur = lock_q ? lock_idx_q : pick;

  always_comb begin
    gnt_o = '0;
    if (lock_q || found) gnt_o[cur] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q     <= 1'b0;
      lock_idx_q <= '0;
      ptr_q      <= '0;
    end else if (lock_q || found) begin
      if (xfer_i && last_i[cur]) begin
        lock_q <= 1'b0;
        ptr_q  <= (cur == IW'(N-1)) ? '0 : cur + 1'b1;
      end else begin
        lock_q     <= 1'b1;
        lock_idx_q <= cur;
      end
    end
  end
endmodule

// File: rtl/omd_router.sv
`timescale 1ns/1ps
module omd_router
  import omd_pkg::*;
#(
  parameter int               N_CALLER = 4,
  parameter int               N_FU     = 4,
  parameter logic [N_FU*8-1:0] FU_MAP  = {8'h22, 8'h21, 8'h12, 8'h11}
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [N_CALLER-1:0]              req_valid_i,
  input  logic [N_CALLER-1:0][WORD_W-1:0]  req_data_i,
  output logic [N_CALLER-1:0]              req_ready_o,
  output logic [N_FU-1:0]                  fu_valid_o,
  output logic [N_FU-1:0][WORD_W-1:0]      fu_data_o,
  input  logic [N_FU-1:0]                  fu_ready_i,
  input  logic [N_FU-1:0]                  rsp_valid_i,
  input  logic [N_FU-1:0][WORD_W-1:0]      rsp_data_i,
  output logic [N_FU-1:0]                  rsp_ready_o,
  output logic [N_CALLER-1:0]              cl_valid_o,
  output logic [N_CALLER-1:0][WORD_W-1:0]  cl_data_o,
  input  logic [N_CALLER-1:0]              cl_ready_i
);
  localparam int FW = (N_FU > 1) ? $clog2(N_FU) : 1;
  localparam int CW = (N_CALLER > 1) ? $clog2(N_CALLER) : 1;

  // request side: tgt msb marks an unmatched key
  logic [N_CALLER-1:0]         rq_hdr, rq_last, err_req, err_sel;
  logic [N_CALLER-1:0][FW:0]   rq_tgt;
  logic [N_FU-1:0][N_CALLER-1:0] fu_req, fu_gnt;
  // reply side
  logic [N_FU-1:0]             rp_hdr, rp_last;
  logic [N_FU-1:0][CW-1:0]     rp_tgt;
  logic [N_CALLER-1:0][N_FU-1:0] cl_req, cl_gnt;

  for (genvar i = 0; i < N_CALLER; i++) begin : g_rq
    logic [N_FU-1:0] hit;
    logic [FW-1:0]   hit_idx;
    logic            drop;
    logic [FW-1:0]   sel;

    for (genvar j = 0; j < N_FU; j++) begin : g_key
      assign hit[j] = (key_of(req_data_i[i]) == FU_MAP[j*8 +: 8]);
      assign fu_req[j][i] = req_valid_i[i] && !drop && (sel == FW'(j));
    end

    always_comb begin
      hit_idx = '0;
      for (int j = N_FU - 1; j >= 0; j--) if (hit[j]) hit_idx = FW'(j);
    end

    omd_pkt_seq #(.TGT_W(FW + 1)) u_seq (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .hs_i   (req_valid_i[i] && req_ready_o[i]),
      .len_i  (len_of(req_data_i[i])),
      .tgt_i  ({~|hit, hit_idx}),
      .hdr_o  (rq_hdr[i]),
      .last_o (rq_last[i]),
      .tgt_o  (rq_tgt[i])
    );

    assign drop       = rq_tgt[i][FW];
    assign sel        = rq_tgt[i][FW-1:0];
    assign err_req[i] = req_valid_i[i] && rq_hdr[i] && drop;

    always_comb begin
      if (drop) req_ready_o[i] = rq_hdr[i] ? (err_sel[i] && cl_ready_i[i]) : 1'b1;
      else      req_ready_o[i] = fu_gnt[sel][i] && fu_ready_i[sel];
    end
  end

  for (genvar j = 0; j < N_FU; j++) begin : g_fu
    logic [WORD_W-1:0] d;

    omd_rr_arb #(.N(N_CALLER)) u_arb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (fu_req[j]),
      .last_i (rq_last),
      .xfer_i (fu_valid_o[j] && fu_ready_i[j]),
      .gnt_o  (fu_gnt[j])
    );

    always_comb begin
      d = '0;
      for (int i = 0; i < N_CALLER; i++)
        if (fu_gnt[j][i]) d = rq_hdr[i] ? stamp_src(req_data_i[i], PORT_W'(i)) : req_data_i[i];
    end

    assign fu_valid_o[j] = |(fu_gnt[j] & fu_req[j]);
    assign fu_data_o[j]  = d;

    omd_pkt_seq #(.TGT_W(CW)) u_seq (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .hs_i   (rsp_valid_i[j] && rsp_ready_o[j]),
      .len_i  (len_of(rsp_data_i[j])),
      .tgt_i  (rsp_data_i[j][CW-1:0]),
      .hdr_o  (rp_hdr[j]),
      .last_o (rp_last[j]),
      .tgt_o  (rp_tgt[j])
    );

    assign rsp_ready_o[j] = cl_gnt[rp_tgt[j]][j] && cl_ready_i[rp_tgt[j]];
  end

  for (genvar i = 0; i < N_CALLER; i++) begin : g_cl
    logic              err_hold_q;
    logic [WORD_W-1:0] d;

    for (genvar j = 0; j < N_FU; j++) begin : g_src
      assign cl_req[i][j] = rsp_valid_i[j] && (rp_tgt[j] == CW'(i));
    end

    // a presented error word blocks new reply grants until taken
    omd_rr_arb #(.N(N_FU)) u_arb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (cl_req[i] & {N_FU{!err_hold_q}}),
      .last_i (rp_last),
      .xfer_i (cl_valid_o[i] && cl_ready_i[i] && !err_sel[i]),
      .gnt_o  (cl_gnt[i])
    );

    assign err_sel[i] = err_req[i] && (err_hold_q || !(|cl_gnt[i]));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) err_hold_q <= 1'b0;
      else         err_hold_q <= err_sel[i] && !cl_ready_i[i];
    end

    always_comb begin
      d = '0;
      for (int j = 0; j < N_FU; j++)
        if (cl_gnt[i][j]) d = rp_hdr[j] ? clr_err(rsp_data_i[j]) : rsp_data_i[j];
      if (err_sel[i]) d = err_reply(req_data_i[i], PORT_W'(i));
    end

    assign cl_valid_o[i] = |(cl_gnt[i] & cl_req[i]) || err_sel[i];
    assign cl_data_o[i]  = d;
  end
endmodule

// File: rtl/omd_router_chk.sv
`timescale 1ns/1ps
module omd_router_chk #(
  parameter int N_CALLER = 4,
  parameter int N_FU     = 4
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [N_CALLER-1:0]           req_valid_i,
  input logic [N_CALLER-1:0]           req_ready_o,
  input logic [N_FU-1:0]               fu_valid_o,
  input logic [N_FU-1:0][31:0]         fu_data_o,
  input logic [N_FU-1:0]               fu_ready_i,
  input logic [N_FU-1:0]               rsp_valid_i,
  input logic [N_FU-1:0]               rsp_ready_o,
  input logic [N_CALLER-1:0]           cl_valid_o,
  input logic [N_CALLER-1:0][31:0]     cl_data_o,
  input logic [N_CALLER-1:0]           cl_ready_i
);
  for (genvar j = 0; j < N_FU; j++) begin : g_fu
    AST_FU_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fu_valid_o[j] && !fu_ready_i[j] |=> fu_valid_o[j] && $stable(fu_data_o[j])); // R5
    AST_FU_FROM_CALLER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fu_valid_o[j] && fu_ready_i[j] |-> (req_valid_i & req_ready_o) != '0); // R3
  end

  for (genvar i = 0; i < N_CALLER; i++) begin : g_cl
    AST_CL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cl_valid_o[i] && !cl_ready_i[i] |=> cl_valid_o[i] && $stable(cl_data_o[i])); // R8
    AST_CL_FROM_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cl_valid_o[i] && cl_ready_i[i] |->
        ((rsp_valid_i & rsp_ready_o) != '0) || ((req_valid_i & req_ready_o) != '0)); // R6
  end
endmodule

bind omd_router omd_router_chk #(.N_CALLER(N_CALLER), .N_FU(N_FU)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .fu_valid_o  (fu_valid_o),
  .fu_data_o   (fu_data_o),
  .fu_ready_i  (fu_ready_i),
  .rsp_valid_i (rsp_valid_i),
  .rsp_ready_o (rsp_ready_o),
  .cl_valid_o  (cl_valid_o),
  .cl_data_o   (cl_data_o),
  .cl_ready_i  (cl_ready_i)
);

// File: tb/omd_router_tb.sv
`timescale 1ns/1ps
module omd_router_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic [3:0]       req_valid = '0;
  logic [3:0][31:0] req_data  = '0;
  logic [3:0]       fu_ready  = '1;
  logic [3:0]       rsp_valid = '0;
  logic [3:0][31:0] rsp_data  = '0;
  logic [3:0]       cl_ready  = '1;
  logic [3:0]       req_ready_o, fu_valid_o, rsp_ready_o, cl_valid_o;
  logic [3:0][31:0] fu_data_o, cl_data_o;

  omd_router u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_data_i(req_data), .req_ready_o(req_ready_o),
    .fu_valid_o(fu_valid_o), .fu_data_o(fu_data_o), .fu_ready_i(fu_ready),
    .rsp_valid_i(rsp_valid), .rsp_data_i(rsp_data), .rsp_ready_o(rsp_ready_o),
    .cl_valid_o(cl_valid_o), .cl_data_o(cl_data_o), .cl_ready_i(cl_ready)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] fu_q [4][$];
  logic [31:0] cl_q [4][$];
  logic both_seen = 1'b0;

  always @(negedge clk) begin
    if (rst_ni) begin
      for (int j = 0; j < 4; j++) begin
        if (fu_valid_o[j] && fu_ready[j]) fu_q[j].push_back(fu_data_o[j]);
        if (cl_valid_o[j] && cl_ready[j]) cl_q[j].push_back(cl_data_o[j]);
      end
      if (fu_valid_o[0] && fu_valid_o[3]) both_seen = 1'b1;
    end
  end

  function automatic logic [31:0] hdr(int m, int c, int inst, int len, int port, bit err = 0);
    return {4'(m), 4'(c), 8'(inst), 2'(len), err, 5'b0, 8'(port)};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic clear_q();
    for (int j = 0; j < 4; j++) begin
      fu_q[j].delete();
      cl_q[j].delete();
    end
  endtask

  task automatic send_req(input int c, input int n, input logic [31:0] w [4]);
    for (int k = 0; k < n; k++) begin
      req_valid[c] = 1'b1;
      req_data[c]  = w[k];
      @(negedge clk);
      while (!req_ready_o[c]) @(negedge clk);
      @(posedge clk); #1;
    end
    req_valid[c] = 1'b0;
  endtask

  task automatic send_rsp(input int f, input int n, input logic [31:0] w [4]);
    for (int k = 0; k < n; k++) begin
      rsp_valid[f] = 1'b1;
      rsp_data[f]  = w[k];
      @(negedge clk);
      while (!rsp_ready_o[f]) @(negedge clk);
      @(posedge clk); #1;
    end
    rsp_valid[f] = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 fu_valid after reset", 32'(fu_valid_o), 32'h0);
    chk("R1 cl_valid after reset", 32'(cl_valid_o), 32'h0);
  endtask

  task automatic t_dispatch();
    clear_q();
    send_req(1, 3, '{hdr(1, 2, 'h5A, 2, 'hFF), 32'h1111_0001, 32'h1111_0002, 32'h0});
    send_req(0, 1, '{hdr(2, 1, 'h07, 0, 0), 32'h0, 32'h0, 32'h0});
    idle(2);
    chk("R2 count at unit1", 32'(fu_q[1].size()), 32'd3);
    chk("R2 stamped header", fu_q[1][0], hdr(1, 2, 'h5A, 2, 1));
    chk("R2 param 1", fu_q[1][1], 32'h1111_0001);
    chk("R2 param 2", fu_q[1][2], 32'h1111_0002);
    chk("R2 zero-length to unit2", fu_q[2][0], hdr(2, 1, 'h07, 0, 0));
    chk("R2 nothing at unit0", 32'(fu_q[0].size() + fu_q[3].size()), 32'd0);
  endtask

  task automatic t_concurrent();
    clear_q();
    both_seen = 1'b0;
    fork
      send_req(0, 2, '{hdr(1, 1, 'h01, 1, 0), 32'hAAAA_0000, 32'h0, 32'h0});
      send_req(3, 2, '{hdr(2, 2, 'h03, 1, 0), 32'hBBBB_0003, 32'h0, 32'h0});
    join
    idle(2);
    chk("R10 units 0 and 3 active together", 32'(both_seen), 32'd1);
    chk("R10 unit0 header", fu_q[0][0], hdr(1, 1, 'h01, 1, 0));
    chk("R10 unit3 header", fu_q[3][0], hdr(2, 2, 'h03, 1, 3));
    chk("R10 unit3 param", fu_q[3][1], 32'hBBBB_0003);
  endtask

  task automatic t_round_robin();
    int s [3];
    clear_q();
    fork
      send_req(0, 4, '{hdr(1, 1, 'h40, 3, 'hFF), 32'hC000_0001, 32'hC000_0002, 32'hC000_0003});
      send_req(1, 4, '{hdr(1, 1, 'h41, 3, 'hFF), 32'hC000_0101, 32'hC000_0102, 32'hC000_0103});
      send_req(2, 4, '{hdr(1, 1, 'h42, 3, 'hFF), 32'hC000_0201, 32'hC000_0202, 32'hC000_0203});
    join
    idle(2);
    chk("R3 twelve words at unit0", 32'(fu_q[0].size()), 32'd12);
    for (int k = 0; k < 3; k++) begin
      s[k] = int'(fu_q[0][4*k][7:0]);
      chk("R3 header of packet", fu_q[0][4*k], hdr(1, 1, 'h40 + s[k], 3, s[k]));
      for (int n = 1; n < 4; n++)
        chk("R3 contiguous params", fu_q[0][4*k+n], 32'hC000_0000 | 32'(s[k] << 8) | 32'(n));
    end
    chk("R4 second grant follows first", 32'(s[1]), 32'((s[0] + 1) % 3));
    chk("R4 third grant follows second", 32'(s[2]), 32'((s[1] + 1) % 3));
  endtask

  task automatic t_stall();
    clear_q();
    fu_ready[2] = 1'b0;
    fork
      send_req(2, 2, '{hdr(2, 1, 'h66, 1, 0), 32'hDEAD_0002, 32'h0, 32'h0});
    join_none
    idle(4);
    @(negedge clk);
    chk("R5 valid held under stall", 32'(fu_valid_o[2]), 32'd1);
    chk("R5 data held under stall", fu_data_o[2], hdr(2, 1, 'h66, 1, 2));
    chk("R5 caller stalled", 32'(req_ready_o[2]), 32'd0);
    @(posedge clk); #1;
    fu_ready[2] = 1'b1;
    wait fork;
    idle(2);
    chk("R5 words after release", 32'(fu_q[2].size()), 32'd2);
    chk("R5 param after release", fu_q[2][1], 32'hDEAD_0002);
  endtask

  task automatic t_reply();
    clear_q();
    send_rsp(3, 3, '{hdr(2, 2, 'h10, 2, 2, 1), 32'h5555_0001, 32'hFFFF_FFFF, 32'h0});
    idle(2);
    chk("R6 words at caller2", 32'(cl_q[2].size()), 32'd3);
    chk("R6 header with status cleared", cl_q[2][0], hdr(2, 2, 'h10, 2, 2));
    chk("R6 body word 1", cl_q[2][1], 32'h5555_0001);
    chk("R6 body word 2 untouched", cl_q[2][2], 32'hFFFF_FFFF);
  endtask

  task automatic t_unmatched();
    clear_q();
    send_req(3, 3, '{hdr(7, 7, 'h33, 2, 0), 32'h1100_0000, 32'h1100_0001, 32'h0});
    idle(3);
    chk("R7 nothing dispatched",
        32'(fu_q[0].size() + fu_q[1].size() + fu_q[2].size() + fu_q[3].size()), 32'd0);
    chk("R7 one error word", 32'(cl_q[3].size()), 32'd1);
    chk("R7 error word", cl_q[3][0], hdr(7, 7, 'h33, 0, 3, 1));
    send_req(3, 1, '{hdr(2, 2, 'h44, 0, 0), 32'h0, 32'h0, 32'h0});
    idle(2);
    chk("R7 next request aligned", fu_q[3][0], hdr(2, 2, 'h44, 0, 3));
    chk("R7 no leaked param", 32'(fu_q[0].size()), 32'd0);
  endtask

  task automatic t_priority();
    clear_q();
    cl_ready[1] = 1'b0;
    fork
      send_rsp(0, 1, '{hdr(1, 1, 'h77, 0, 1), 32'h0, 32'h0, 32'h0});
      send_req(1, 1, '{hdr(9, 9, 'h88, 0, 0), 32'h0, 32'h0, 32'h0});
    join_none
    idle(3);
    @(negedge clk);
    chk("R8 reply shown first", cl_data_o[1], hdr(1, 1, 'h77, 0, 1));
    @(posedge clk); #1;
    cl_ready[1] = 1'b1;
    wait fork;
    idle(2);
    chk("R8 two words", 32'(cl_q[1].size()), 32'd2);
    chk("R8 reply first", cl_q[1][0], hdr(1, 1, 'h77, 0, 1));
    chk("R8 error second", cl_q[1][1], hdr(9, 9, 'h88, 0, 1, 1));
  endtask

  task automatic t_reply_rr();
    int s [3];
    clear_q();
    fork
      send_rsp(0, 2, '{hdr(0, 0, 'hA0, 1, 0), 32'hD000_0000, 32'h0, 32'h0});
      send_rsp(1, 2, '{hdr(0, 0, 'hA1, 1, 0), 32'hD000_0001, 32'h0, 32'h0});
      send_rsp(2, 2, '{hdr(0, 0, 'hA2, 1, 0), 32'hD000_0002, 32'h0, 32'h0});
    join
    idle(2);
    chk("R9 six words at caller0", 32'(cl_q[0].size()), 32'd6);
    for (int k = 0; k < 3; k++) begin
      s[k] = int'(cl_q[0][2*k+1][3:0]);
      chk("R9 header matches body", cl_q[0][2*k], hdr(0, 0, 'hA0 + s[k], 1, 0));
    end
    chk("R9 second grant follows first", 32'(s[1]), 32'((s[0] + 1) % 3));
    chk("R9 third grant follows second", 32'(s[2]), 32'((s[1] + 1) % 3));
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R3 watchdog: act=running exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    t_reset();
    idle(1);
    t_dispatch();
    t_concurrent();
    t_round_robin();
    t_stall();
    t_reply();
    t_unmatched();
    t_priority();
    t_reply_rr();
    idle(2);
    finish_run();
  end
endmodule